// File: doc/BRIEF.md
# ECC Error Capture and Status

This block sits beside a memory controller's ECC check logic and keeps the error record that software inspects. Each read that the checker flags arrives as a one-cycle strobe, single-bit or multi-bit, together with the raw data words, the check byte, the address and the transaction attributes. The first such event freezes a capture record. Later events only raise a sticky flag showing that more errors followed. Single-bit events also advance a saturating counter.

Three further error sources each arrive as a strobe and each set a sticky flag of its own: address parity, auto-calibration and memory-select. Software reads the status through a small word-indexed register port. It clears the detect flags by writing ones to them, so writing back the value it read clears every set flag. It resets the counter by writing its low byte. A single level output stays high for as long as any error remains unacknowledged.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every register reads zero and `err_pending` is low.
- R2: Error strobes set sticky bits in the detect register (index 0). Single-bit ECC sets bit 2, multi-bit ECC sets bit 3, memory-select sets bit 0, auto-calibration sets bit 7 and address parity sets bit 8. A bit stays set until software clears it.
- R3: A single-bit or multi-bit strobe that arrives while no capture is held latches the record. The register indices are: 2 upper data word, 3 lower data word, 4 check byte in bits [7:0], 5 attributes, 6 address, 7 extended address in bits [3:0]. Unused upper bits read zero.
- R4: A capture is held while detect bit 2 or bit 3 is set. An ECC strobe during that time leaves the record unchanged and sets detect bit 31.
- R5: A write to index 0 clears exactly the flags written as 1, and bits written as 0 are unaffected. A flag whose strobe arrives in the same cycle as its clear stays set.
- R6: Each single-bit strobe adds one to the counter, which reads in bits [7:0] of index 1. Bits [31:8] of index 1 read zero.
- R7: The counter saturates at 0xFF and does not wrap.
- R8: A write to index 1 loads the counter from bits [7:0] of the write data, so writing zeros clears it. A single-bit strobe in the same cycle adds one on top of the loaded value.
- R9: Once software has cleared detect bits 2 and 3, the next ECC strobe latches a fresh record.
- R10: `err_pending` is high exactly when any detect bit is set or the counter is nonzero.
- R11: Writes to indices 2 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_sbe | input | 1 | Single-bit ECC error strobe |
| ev_mbe | input | 1 | Multi-bit ECC error strobe |
| ev_addr_par | input | 1 | Address parity error strobe |
| ev_calib | input | 1 | Auto-calibration error strobe |
| ev_sel | input | 1 | Memory-select error strobe |
| rd_data_hi | input | 32 | Raw upper data word of the failing read |
| rd_data_lo | input | 32 | Raw lower data word of the failing read |
| rd_check | input | 8 | Raw check byte of the failing read |
| rd_attr | input | 32 | Transaction attributes |
| rd_addr | input | 32 | Failing address, low 32 bits |
| rd_addr_ext | input | 4 | Failing address, extended bits |
| reg_addr | input | 3 | Register word index |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| err_pending | output | 1 | Level output: unacknowledged error present |

## Verification
The bench builds the block with its default parameters: an 8-bit single-bit counter, 32-bit data, attribute and address words, a check byte and a 4-bit extended address. With an 8-bit counter, a burst of 260 back-to-back single-bit strobes drives it past its ceiling in a few hundred cycles. That makes the saturation corner and the repeated-event flag reachable in one run. The narrow fields are loaded with values that use every bit, so a fault in the zero-extension or in the field routing shows up on the read port.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int REG_W     = 32;
    localparam int DWORD_W   = 32;
    localparam int CHK_W     = 8;
    localparam int ATTR_W    = 32;
    localparam int ADR_W     = 32;
    localparam int XADR_W    = 4;

    // detect register bit positions (software decodes these)
    localparam int DET_MULTI = 31;
    localparam int DET_APAR  = 8;
    localparam int DET_CAL   = 7;
    localparam int DET_MBE   = 3;
    localparam int DET_SBE   = 2;
    localparam int DET_SEL   = 0;

    typedef enum logic [2:0] {
        RI_DETECT = 3'd0,
        RI_SBCNT  = 3'd1,
        RI_DHI    = 3'd2,
        RI_DLO    = 3'd3,
        RI_CHK    = 3'd4,
        RI_ATTR   = 3'd5,
        RI_ADDR   = 3'd6,
        RI_XADDR  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic sbe;
        logic mbe;
        logic apar;
        logic cal;
        logic sel;
    } err_ev_t;

    typedef struct packed {
        logic multi;
        logic apar;
        logic cal;
        logic mbe;
        logic sbe;
        logic sel;
    } det_flags_t;

    typedef struct packed {
        logic [DWORD_W-1:0] dhi;
        logic [DWORD_W-1:0] dlo;
        logic [CHK_W-1:0]   chk;
        logic [ATTR_W-1:0]  attr;
        logic [ADR_W-1:0]   addr;
        logic [XADR_W-1:0]  xaddr;
    } cap_rec_t;

    function automatic logic [REG_W-1:0] det_to_word(det_flags_t f);
        logic [REG_W-1:0] w;
        w            = '0;
        w[DET_MULTI] = f.multi;
        w[DET_APAR]  = f.apar;
        w[DET_CAL]   = f.cal;
        w[DET_MBE]   = f.mbe;
        w[DET_SBE]   = f.sbe;
        w[DET_SEL]   = f.sel;
        return w;
    endfunction

    function automatic det_flags_t word_to_det(logic [REG_W-1:0] w);
        det_flags_t f;
        f.multi = w[DET_MULTI];
        f.apar  = w[DET_APAR];
        f.cal   = w[DET_CAL];
        f.mbe   = w[DET_MBE];
        f.sbe   = w[DET_SBE];
        f.sel   = w[DET_SEL];
        return f;
    endfunction

endpackage

// File: rtl/ecc_cap_detect.sv
module ecc_cap_detect
    import ecc_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_ev_t    ev,
    input  logic       clr_we,
    input  det_flags_t clr_mask,
    output det_flags_t flags,
    output logic       held
);

    logic       ecc_ev;
    det_flags_t kept;
    det_flags_t flags_n;

    assign ecc_ev = ev.sbe | ev.mbe;
    assign held   = flags.sbe | flags.mbe;

    always_comb begin
        kept = clr_we ? (flags & ~clr_mask) : flags;
        flags_n       = kept;
        flags_n.sbe   = kept.sbe   | ev.sbe;
        flags_n.mbe   = kept.mbe   | ev.mbe;
        flags_n.apar  = kept.apar  | ev.apar;
        flags_n.cal   = kept.cal   | ev.cal;
        flags_n.sel   = kept.sel   | ev.sel;
        flags_n.multi = kept.multi | (ecc_ev & held);
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_n;
    end

    AST_MULTI_ON_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (ecc_ev && held) |=> flags.multi); // R4
    AST_W1C_SEL: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_mask.sel && !ev.sel) |=> !flags.sel); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_mask.sbe && ev.sbe) |=> flags.sbe); // R5
    AST_STICKY_APAR: assert property (@(posedge clk) disable iff (rst)
        (flags.apar && !(clr_we && clr_mask.apar)) |=> flags.apar); // R2

endmodule

// File: rtl/ecc_cap_counter.sv
module ecc_cap_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             we,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        base  = we ? wval : cnt;
        cnt_n = (inc && (base != CNT_MAX)) ? base + 1'b1 : base;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_n;
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && inc && !we) |=> (cnt == CNT_MAX)); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!we && inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1)); // R6
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!we && !inc) |=> $stable(cnt)); // R6

endmodule

// File: rtl/ecc_cap_record.sv
module ecc_cap_record
    import ecc_cap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  cap_rec_t din,
    output cap_rec_t rec
);

    always_ff @(posedge clk) begin
        if (rst)       rec <= '0;
        else if (load) rec <= din;
    end

    AST_REC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(rec)); // R4
    AST_REC_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (rec == $past(din))); // R3

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ev_sbe,
    input  logic                ev_mbe,
    input  logic                ev_addr_par,
    input  logic                ev_calib,
    input  logic                ev_sel,
    input  logic [DWORD_W-1:0]  rd_data_hi,
    input  logic [DWORD_W-1:0]  rd_data_lo,
    input  logic [CHK_W-1:0]    rd_check,
    input  logic [ATTR_W-1:0]   rd_attr,
    input  logic [ADR_W-1:0]    rd_addr,
    input  logic [XADR_W-1:0]   rd_addr_ext,
    input  logic [2:0]          reg_addr,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                err_pending
);

    err_ev_t          ev;
    det_flags_t       flags;
    det_flags_t       clr_mask;
    logic             held;
    logic             det_we;
    logic             cnt_we;
    logic             rec_load;
    logic [CNT_W-1:0] sb_cnt;
    cap_rec_t         rec_in;
    cap_rec_t         rec;
    logic             wdata_unused;

    assign ev       = '{sbe: ev_sbe, mbe: ev_mbe, apar: ev_addr_par,
                        cal: ev_calib, sel: ev_sel};
    assign det_we   = reg_we && (reg_idx_e'(reg_addr) == RI_DETECT);
    assign cnt_we   = reg_we && (reg_idx_e'(reg_addr) == RI_SBCNT);
    assign clr_mask = word_to_det(reg_wdata);
    assign rec_load = (ev_sbe | ev_mbe) & ~held;
    assign rec_in   = '{dhi: rd_data_hi, dlo: rd_data_lo, chk: rd_check,
                        attr: rd_attr, addr: rd_addr, xaddr: rd_addr_ext};
    assign wdata_unused = ^reg_wdata[30:9];

    ecc_cap_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .clr_we   (det_we),
        .clr_mask (clr_mask),
        .flags    (flags),
        .held     (held)
    );

    ecc_cap_counter #(.CNT_W(CNT_W)) u_counter (
        .clk  (clk),
        .rst  (rst),
        .inc  (ev_sbe),
        .we   (cnt_we),
        .wval (reg_wdata[CNT_W-1:0]),
        .cnt  (sb_cnt)
    );

    ecc_cap_record u_record (
        .clk  (clk),
        .rst  (rst),
        .load (rec_load),
        .din  (rec_in),
        .rec  (rec)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx_e'(reg_addr))
            RI_DETECT: reg_rdata = det_to_word(flags);
            RI_SBCNT:  reg_rdata[CNT_W-1:0]  = sb_cnt;
            RI_DHI:    reg_rdata[DWORD_W-1:0] = rec.dhi;
            RI_DLO:    reg_rdata[DWORD_W-1:0] = rec.dlo;
            RI_CHK:    reg_rdata[CHK_W-1:0]   = rec.chk;
            RI_ATTR:   reg_rdata[ATTR_W-1:0]  = rec.attr;
            RI_ADDR:   reg_rdata[ADR_W-1:0]   = rec.addr;
            RI_XADDR:  reg_rdata[XADR_W-1:0]  = rec.xaddr;
            default:   reg_rdata = '0;
        endcase
    end

    assign err_pending = (|flags) | (|sb_cnt);

    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_pending) |-> $past(ev_sbe | ev_mbe | ev_addr_par | ev_calib | ev_sel | reg_we)); // R10
    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!err_pending && !(ev_sbe | ev_mbe | ev_addr_par | ev_calib | ev_sel | reg_we)) |=> !err_pending); // R10
    AST_FIRST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (rst)
        rec_load |=> (flags.sbe | flags.mbe)); // R3

endmodule

// File: tb/tb_ecc_err_capture.sv
module tb_ecc_err_capture;

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_sbe, ev_mbe, ev_addr_par, ev_calib, ev_sel;
    logic [31:0] rd_data_hi, rd_data_lo, rd_attr, rd_addr;
    logic [7:0]  rd_check;
    logic [3:0]  rd_addr_ext;
    logic [2:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        err_pending;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    ecc_err_capture dut (
        .clk(clk), .rst(rst),
        .ev_sbe(ev_sbe), .ev_mbe(ev_mbe), .ev_addr_par(ev_addr_par),
        .ev_calib(ev_calib), .ev_sel(ev_sel),
        .rd_data_hi(rd_data_hi), .rd_data_lo(rd_data_lo), .rd_check(rd_check),
        .rd_attr(rd_attr), .rd_addr(rd_addr), .rd_addr_ext(rd_addr_ext),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_pending(err_pending)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // drive the payload and strobes for one edge, then release at the next negedge
    task automatic pulse(input logic s, input logic m, input logic ap, input logic ca,
                         input logic se, input logic [31:0] seed);
        ev_sbe = s; ev_mbe = m; ev_addr_par = ap; ev_calib = ca; ev_sel = se;
        rd_data_hi = seed ^ 32'hA5A5_0000; rd_data_lo = ~seed;
        rd_check = seed[7:0] ^ 8'h3C; rd_attr = seed + 32'h1111;
        rd_addr = {seed[15:0], seed[31:16]}; rd_addr_ext = seed[3:0] ^ 4'hF;
        @(posedge clk); @(negedge clk);
        ev_sbe = 0; ev_mbe = 0; ev_addr_par = 0; ev_calib = 0; ev_sel = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_record(input string req, input logic [31:0] seed);
        chk_reg({req, " hi"},   3'd2, seed ^ 32'hA5A5_0000);
        chk_reg({req, " lo"},   3'd3, ~seed);
        chk_reg({req, " chk"},  3'd4, {24'h0, seed[7:0] ^ 8'h3C});
        chk_reg({req, " attr"}, 3'd5, seed + 32'h1111);
        chk_reg({req, " addr"}, 3'd6, {seed[15:0], seed[31:16]});
        chk_reg({req, " xadr"}, 3'd7, {28'h0, seed[3:0] ^ 4'hF});
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) chk_reg("R1 reg zero", 3'(i), 32'h0);
        chk("R1 pending low", {31'h0, err_pending}, 32'h0);
    endtask

    task automatic t_first_sbe();
        pulse(1, 0, 0, 0, 0, 32'h1234_5670);
        chk_reg("R2 sbe bit2", 3'd0, 32'h0000_0004);
        chk_reg("R6 count one", 3'd1, 32'h0000_0001);
        chk_record("R3 first capture", 32'h1234_5670);
        chk("R10 pending high", {31'h0, err_pending}, 32'h1);
    endtask

    task automatic t_repeat_mbe();
        pulse(0, 1, 0, 0, 0, 32'hDEAD_BEEF);
        chk_reg("R4 multi flag", 3'd0, 32'h8000_000C);
        chk_record("R4 record held", 32'h1234_5670);
        chk_reg("R6 mbe no count", 3'd1, 32'h0000_0001);
    endtask

    task automatic t_readonly();
        for (int i = 2; i < 8; i++) wr(3'(i), 32'hFFFF_FFFF);
        chk_record("R11 writes ignored", 32'h1234_5670);
    endtask

    task automatic t_clear();
        wr(3'd0, 32'h0);
        chk_reg("R5 zero write keeps", 3'd0, 32'h8000_000C);
        wr(3'd0, 32'h0000_0008);
        chk_reg("R5 partial clear", 3'd0, 32'h8000_0004);
        wr(3'd0, 32'h8000_0004);
        chk_reg("R5 full clear", 3'd0, 32'h0);
        chk("R10 count keeps pending", {31'h0, err_pending}, 32'h1);
        wr(3'd1, 32'h0);
        chk_reg("R8 count cleared", 3'd1, 32'h0);
        chk("R10 pending low", {31'h0, err_pending}, 32'h0);
    endtask

    task automatic t_release();
        pulse(0, 1, 0, 0, 0, 32'h0F0F_9ABC);
        chk_reg("R9 new mbe flag", 3'd0, 32'h0000_0008);
        chk_record("R9 new capture", 32'h0F0F_9ABC);
        wr(3'd0, 32'hFFFF_FFFF);
        chk_reg("R5 all ones clears", 3'd0, 32'h0);
    endtask

    task automatic t_other_flags();
        pulse(0, 0, 1, 1, 1, 32'h5555_5555);
        chk_reg("R2 other flags", 3'd0, 32'h0000_0181);
        chk_record("R3 non-ecc no capture", 32'h0F0F_9ABC);
        chk("R10 pending other", {31'h0, err_pending}, 32'h1);
        pulse(0, 0, 0, 0, 0, 32'h0);
        chk_reg("R2 sticky", 3'd0, 32'h0000_0181);
        wr(3'd0, 32'h0000_0181);
        chk("R10 pending cleared", {31'h0, err_pending}, 32'h0);
    endtask

    task automatic t_saturate();
        ev_sbe = 1'b1;
        rd_data_hi = 32'h0; rd_data_lo = 32'h0;
        for (int i = 0; i < 260; i++) begin
            @(posedge clk); @(negedge clk);
        end
        ev_sbe = 1'b0;
        chk_reg("R7 saturate", 3'd1, 32'h0000_00FF);
        chk_reg("R4 burst multi", 3'd0, 32'h8000_0004);
        wr(3'd1, 32'hFFFF_FF00);
        chk_reg("R8 load zero upper ignored", 3'd1, 32'h0);
        wr(3'd1, 32'h0000_0042);
        chk_reg("R8 load value", 3'd1, 32'h0000_0042);
        wr(3'd0, 32'h8000_0004);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_same_cycle();
        pulse(1, 0, 0, 0, 0, 32'h7777_1111);
        reg_addr = 3'd0; reg_wdata = 32'h0000_0004; reg_we = 1'b1; ev_sbe = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0; ev_sbe = 1'b0;
        chk_reg("R5 set wins", 3'd0, 32'h8000_0004);
        reg_addr = 3'd1; reg_wdata = 32'h0000_0005; reg_we = 1'b1; ev_sbe = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0; ev_sbe = 1'b0;
        chk_reg("R8 load plus strobe", 3'd1, 32'h0000_0006);
        chk_record("R4 same-cycle held", 32'h7777_1111);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        ev_sbe = 0; ev_mbe = 0; ev_addr_par = 0; ev_calib = 0; ev_sel = 0;
        rd_data_hi = '0; rd_data_lo = '0; rd_check = '0; rd_attr = '0;
        rd_addr = '0; rd_addr_ext = '0;
        reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_sbe();
        t_repeat_mbe();
        t_readonly();
        t_clear();
        t_release();
        t_other_flags();
        t_saturate();
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule